// File: doc/BRIEF.md
# First-Error Pointer Error Logger

This block gathers single-cycle error events from a set of sources. Each source has a sticky status bit that software clears by writing a one to it. A per-source mask bit decides whether a logged error counts as reported. Reported errors raise one combined flag. A first-error pointer records the bit index of the earliest reported error, together with a lock flag.

The pointer locks when the first unmasked error is logged. When several unmasked errors arrive together, it takes the lowest index among them. It then ignores every later event. It rearms only after no unmasked status bit is left, whether those bits were cleared or masked.

The status, mask, pointer and lock flag are kept across a normal (soft) reset. Only the power-on reset clears them. Software reaches the state through a small register port. Reads are registered and return one cycle after the request.

Top module: `err_first_logger`

## Requirements
- R1: Power-on reset (`por_n` low) clears every status bit, every mask bit, the pointer and the lock flag, and `err_any` reads 0.
- R2: A one-cycle pulse on `err_in[i]` sets status bit i (register 0, bit i) whether or not source i is masked, and the bit stays set until software clears it.
- R3: Writing register 0 clears each status bit whose data bit is 1; data bits of 0 leave their status bits unchanged; a new pulse on a bit wins over a clear of that bit in the same cycle.
- R4: Register 1 is the mask (read/write, bit i for source i, 1 = not reported); `err_any` is 1 exactly when some status bit with a 0 mask bit is set.
- R5: Register 2 holds the pointer in bits [PTR_W-1:0] and the lock flag in bit DATA_W-1; the first unmasked error loads its index and sets the lock flag.
- R6: When several unmasked errors arrive in the same cycle on an unlocked pointer, the pointer takes the lowest index among them.
- R7: While the pointer is locked, later errors leave the pointer and the lock flag unchanged.
- R8: An error from a masked source never loads the pointer or sets the lock flag.
- R9: Once no unmasked status bit remains set, whether by clearing or by masking, the lock flag drops and the pointer reads 0.
- R10: If an unmasked error arrives in the same cycle as the clear of the last remaining unmasked error, the error is logged and the pointer relocks to the new index.
- R11: Soft reset (`soft_rst_n` low) leaves status, mask, pointer and lock flag unchanged; it only clears `rd_valid` and `rd_data`.
- R12: Writes to register 2 and register 3 have no effect, and register 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears all state |
| soft_rst_n | input | 1 | Synchronous normal reset, active low; clears only the read path |
| err_in | input | NUM_SRC | One-cycle error pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 status, 1 mask, 2 pointer, 3 reserved |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid one cycle after `rd_en` |
| rd_valid | output | 1 | High for one cycle when `rd_data` holds a read result |
| err_any | output | 1 | OR of all unmasked status bits |

## Verification
The pointer is driven with four kinds of stimulus. Two sources firing together shows the lowest-index choice. A single later error shows that the lock holds. Errors on masked sources show that they are logged but leave the pointer alone. An error that coincides with clearing the last live error shows the relock, as distinct from a plain rearm. Rearm is reached in two ways, by write-one-to-clear and by masking, so a design that ignores the mask when it rearms is caught. A soft reset is placed between logging and clearing, which separates the sticky state from the read path.

// File: rtl/err_first_logger.sv
module err_first_logger #(
  parameter int NUM_SRC = 8,
  parameter int PTR_W   = 5,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               soft_rst_n,
  input  logic [NUM_SRC-1:0] err_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic               err_any
);

  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_PTR  = 2'd2;

  logic [NUM_SRC-1:0] status_q, mask_q;
  logic [PTR_W-1:0]   ptr_q, first_idx;
  logic               lock_q;

  wire [NUM_SRC-1:0] wdat    = wr_data[NUM_SRC-1:0];
  wire               unused_hi = ^wr_data[DATA_W-1:NUM_SRC];
  wire [NUM_SRC-1:0] clr     = (wr_en && addr == A_STAT) ? wdat : '0;
  wire [NUM_SRC-1:0] new_unm = err_in & ~mask_q;
  wire [NUM_SRC-1:0] kept    = status_q & ~clr;
  wire               held    = lock_q && |(kept & ~mask_q);

  assign err_any = |(status_q & ~mask_q);

  always_comb begin
    first_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (new_unm[i]) first_idx = PTR_W'(i);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      status_q <= '0;
      mask_q   <= '0;
      ptr_q    <= '0;
      lock_q   <= 1'b0;
    end else begin
      status_q <= kept | err_in;
      if (wr_en && addr == A_MASK) mask_q <= wdat;
      if (!held) begin
        if (|new_unm) begin
          ptr_q  <= first_idx;
          lock_q <= 1'b1;
        end else begin
          ptr_q  <= '0;
          lock_q <= 1'b0;
        end
      end
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr)
      A_STAT: rd_mux = DATA_W'(status_q);
      A_MASK: rd_mux = DATA_W'(mask_q);
      A_PTR: begin
        rd_mux[PTR_W-1:0] = ptr_q;
        rd_mux[DATA_W-1]  = lock_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else if (!soft_rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

endmodule

module err_first_logger_chk #(
  parameter int NUM_SRC = 8,
  parameter int PTR_W   = 5
) (
  input logic               clk,
  input logic               por_n,
  input logic               soft_rst_n,
  input logic [NUM_SRC-1:0] err_in,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [PTR_W-1:0]   ptr_q,
  input logic               lock_q,
  input logic               rd_valid
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // R2
    err_sets_status_chk: assert property (@(posedge clk) disable iff (!por_n)
      err_in[i] |=> status_q[i]);
  end

  // R9
  idle_ptr_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    !lock_q |-> ptr_q == '0);

  // R5
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |-> int'(ptr_q) < NUM_SRC);

  // R8
  lock_needs_unmasked_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(lock_q) |-> $past(|(err_in & ~mask_q)));

  // R7
  ptr_move_needs_event_chk: assert property (@(posedge clk) disable iff (!por_n)
    (lock_q && !$stable(ptr_q)) |-> $past(|(err_in & ~mask_q)));

  // R11
  soft_reset_read_chk: assert property (@(posedge clk) disable iff (!por_n)
    !soft_rst_n |=> !rd_valid);

endmodule

bind err_first_logger err_first_logger_chk #(.NUM_SRC(NUM_SRC), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .err_in(err_in),
  .status_q(status_q), .mask_q(mask_q), .ptr_q(ptr_q), .lock_q(lock_q),
  .rd_valid(rd_valid)
);

// File: tb/err_first_logger_test.sv
module err_first_logger_test;
  localparam int N = 8;
  localparam int DW = 32;

  logic clk = 0, por_n = 0, soft_rst_n = 1;
  logic [N-1:0] err_in = '0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, err_any;

  int compared = 0, mismatched = 0;
  logic [DW-1:0] q_data[$];
  string q_tag[$];

  always #5 clk = ~clk;

  err_first_logger uut (
    .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .err_in(err_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .err_any(err_any)
  );

  always @(negedge clk) begin
    if (rd_valid) begin
      if (q_data.size() == 0) begin
        mismatched++;
        $display("FAIL unexpected read result, actual %h expected none", rd_data);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = q_data.pop_front();
        t = q_tag.pop_front();
        compared++;
        if (rd_data !== e) begin
          mismatched++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [DW-1:0] exp, input string tag);
    q_data.push_back(exp);
    q_tag.push_back(tag);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d, input logic [N-1:0] pulse);
    addr = a; wr_data = d; wr_en = 1; err_in = pulse;
    @(negedge clk);
    wr_en = 0; err_in = '0;
  endtask

  task automatic pulse(input logic [N-1:0] p);
    err_in = p;
    @(negedge clk);
    err_in = '0;
  endtask

  task automatic chk_any(input logic exp, input string tag);
    compared++;
    if (err_any !== exp) begin
      mismatched++;
      $display("FAIL %s: err_any actual %b expected %b", tag, err_any, exp);
    end
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    // R1
    chk_any(1'b0, "R1 reset err_any");
    rd(2'd0, 32'h0, "R1 status reset");
    rd(2'd1, 32'h0, "R1 mask reset");
    rd(2'd2, 32'h0, "R1 pointer reset");

    pulse(8'h48);
    chk_any(1'b1, "R4 err_any on unmasked");
    rd(2'd0, 32'h48, "R2 status capture");
    rd(2'd2, 32'h8000_0003, "R5 R6 lowest index locks");

    pulse(8'h02);
    rd(2'd0, 32'h4A, "R2 later error logged");
    rd(2'd2, 32'h8000_0003, "R7 pointer held");

    wr(2'd2, 32'h0000_001F, '0);
    wr(2'd3, 32'hFFFF_FFFF, '0);
    rd(2'd2, 32'h8000_0003, "R12 pointer write ignored");
    rd(2'd3, 32'h0, "R12 reserved reads zero");

    wr(2'd0, 32'h08, '0);
    rd(2'd0, 32'h42, "R3 w1c clears one bit");
    rd(2'd2, 32'h8000_0003, "R7 R9 still locked with errors left");
    wr(2'd0, 32'h00, '0);
    rd(2'd0, 32'h42, "R3 zero write no effect");

    soft_rst_n = 0;
    @(negedge clk);
    soft_rst_n = 1;
    rd(2'd0, 32'h42, "R11 status sticky");
    rd(2'd2, 32'h8000_0003, "R11 pointer sticky");

    wr(2'd0, 32'h42, '0);
    chk_any(1'b0, "R9 err_any after clear");
    rd(2'd2, 32'h0, "R9 rearm by clear");

    wr(2'd1, 32'h05, '0);
    pulse(8'h05);
    chk_any(1'b0, "R4 masked not reported");
    rd(2'd0, 32'h05, "R2 masked still logged");
    rd(2'd2, 32'h0, "R8 masked does not lock");
    rd(2'd1, 32'h05, "R4 mask readback");

    pulse(8'h10);
    rd(2'd2, 32'h8000_0004, "R5 unmasked locks past masked");

    wr(2'd0, 32'h10, 8'h80);
    rd(2'd0, 32'h85, "R10 status after clear plus new");
    rd(2'd2, 32'h8000_0007, "R10 relock to new index");

    wr(2'd0, 32'h80, 8'h80);
    rd(2'd0, 32'h85, "R3 set wins over clear");
    rd(2'd2, 32'h8000_0007, "R10 same-bit relock");

    wr(2'd1, 32'hFF, '0);
    @(negedge clk);
    chk_any(1'b0, "R4 all masked");
    rd(2'd2, 32'h0, "R9 rearm by masking");

    repeat (2) @(negedge clk);
    if (q_data.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q_data.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule